// File: doc/BRIEF.md
# Radio Status and Control Pin Logic

This block drives four digital output pins of a radio transceiver. The pins are driven from configuration bits and from internal status signals. The first is the data clock pin. It can run the data clock through unchanged. It can also serve as an interrupt line to a host controller, in one of two ways:

- It stays high until the synthesizer reports lock.
- It stays high until carrier sense is seen.

Two amplifier enable pins either follow the internal PA-on and LNA-on status at a chosen polarity, or they act as plain general-purpose outputs. A lock pin shows a fixed low level, a fixed high level or the synthesizer lock status, chosen by a 4-bit selector.

The data clock gate picks its mode only at falling edges of the data clock. A mode change therefore never shortens a clock pulse. The three amplifier and lock pins are registered on the system clock. The sender must append at least two dummy bits after a payload when the receiver uses carrier-sense gating. This is because carrier sense runs two bit periods ahead of the matching data.

Top module: `radio_pin_ctrl`

## Requirements
- R1: With `lock_gate_en`=1 and `pd_mode`=2'b01, the data clock pin reads 1 while `pll_lock`=0 and 0 while `pll_lock`=1. The new level takes effect at the next falling edge of `dclk_in`.
- R2: With `lock_gate_en`=1 and `pd_mode` other than 2'b01, and carrier-sense gating not applying, `dclk_pin` equals `dclk_in`.
- R3: With `cs_gate_en`=1 and `rx_mode`=1 (and R1 not applying), `dclk_pin` is held at 1 while `carrier_sense`=0 and follows `dclk_in` while `carrier_sense`=1.
- R4: Carrier-sense gating has no effect in transmit mode (`rx_mode`=0): `dclk_pin` follows `dclk_in`.
- R5: When both the lock-wait condition of R1 and carrier-sense gating apply, the lock-wait behaviour wins.
- R6: The gating mode changes only at a falling edge of `dclk_in`. A condition change while `dclk_in` is high leaves `dclk_pin` unchanged until that edge.
- R7: With `pa_func`=1, `pa_pin` follows `pa_on` one `clk` cycle later: `pa_pin`=`pa_on` when `pa_pol`=1 (active high) and `pa_pin`=!`pa_on` when `pa_pol`=0.
- R8: With `pa_func`=0, `pa_pin` takes the value of `pa_pol` one `clk` cycle later, whatever `pa_on` is.
- R9: `lna_pin` behaves as in R7/R8, using `lna_func`, `lna_pol` and `lna_on` only, independently of the PA controls.
- R10: One `clk` cycle after `lock_sel` is applied, `lock_pin` reads:
  - 0 for `lock_sel`=4'b0000;
  - 1 for `lock_sel`=4'b0001;
  - `pll_lock` for every other code.
- R11: While `rst`=1, `pa_pin`, `lna_pin` and `lock_pin` are 0 after the next `clk` edge, and the data clock gate returns to pass-through after the next `dclk_in` falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the registered pins |
| rst | input | 1 | Synchronous active-high reset |
| dclk_in | input | 1 | Raw data clock |
| pll_lock | input | 1 | Synthesizer lock status |
| carrier_sense | input | 1 | Carrier sense status |
| pa_on | input | 1 | Internal PA is on |
| lna_on | input | 1 | Internal LNA is on |
| rx_mode | input | 1 | 1 = receive, 0 = transmit |
| pd_mode | input | 2 | Power-down mode field; 2'b01 = wait for lock |
| lock_gate_en | input | 1 | Enables lock gating of the data clock |
| cs_gate_en | input | 1 | Enables carrier-sense gating of the data clock |
| pa_func | input | 1 | 1 = PA pin follows status, 0 = direct drive |
| pa_pol | input | 1 | PA polarity / direct value |
| lna_func | input | 1 | 1 = LNA pin follows status, 0 = direct drive |
| lna_pol | input | 1 | LNA polarity / direct value |
| lock_sel | input | 4 | Lock pin source selector |
| dclk_pin | output | 1 | Gated data clock / interrupt pin |
| pa_pin | output | 1 | External PA enable pin |
| lna_pin | output | 1 | External LNA enable pin |
| lock_pin | output | 1 | Lock / general-purpose pin |

## Verification
Some rules are checked by the assertions on every cycle:

- the direct and follow rules of both amplifier pins;
- the three lock-pin selector cases;
- the lock-wait level seen on the data clock pin at each falling edge.

Other behaviours only show up in the bench's directed scenarios:

- pass-through versus hold-high under carrier sense;
- the mode being ignored in transmit;
- priority between the two gates;
- a gating change made while the data clock is high;
- the reset state.

// File: rtl/radio_pin_pkg.sv
package radio_pin_pkg;
  typedef enum logic [1:0] {
    GATE_PASS = 2'b00,
    GATE_HIGH = 2'b01,
    GATE_LOW  = 2'b10
  } gate_sel_t;

  localparam int PD_W = 2;
  localparam logic [PD_W-1:0] PD_LOCKWAIT = 2'b01;
endpackage

// File: rtl/rpl_dclk_gate.sv
module rpl_dclk_gate
  import radio_pin_pkg::*;
#(
  parameter int PDW = PD_W
) (
  input  logic           rst,
  input  logic           dclk_in,
  input  logic           pll_lock,
  input  logic           carrier_sense,
  input  logic           rx_mode,
  input  logic [PDW-1:0] pd_mode,
  input  logic           lock_gate_en,
  input  logic           cs_gate_en,
  output logic           dclk_pin
);
  localparam logic [PDW-1:0] LOCKWAIT_CODE = PDW'(PD_LOCKWAIT);

  gate_sel_t sel_next;
  gate_sel_t sel_q;
  logic      lock_wait;
  logic      cs_active;

  always_comb begin
    lock_wait = lock_gate_en && (pd_mode == LOCKWAIT_CODE);
    cs_active = cs_gate_en && rx_mode;
    if (lock_wait)
      sel_next = pll_lock ? GATE_LOW : GATE_HIGH;
    else if (cs_active)
      sel_next = carrier_sense ? GATE_PASS : GATE_HIGH;
    else
      sel_next = GATE_PASS;
  end

  // Select is updated only while the data clock is low.
  always_ff @(negedge dclk_in) begin
    if (rst) sel_q <= GATE_PASS;
    else     sel_q <= sel_next;
  end

  always_comb begin
    case (sel_q)
      GATE_HIGH: dclk_pin = 1'b1;
      GATE_LOW:  dclk_pin = 1'b0;
      default:   dclk_pin = dclk_in;
    endcase
  end

  AST_LOCKWAIT_LEVEL: assert property (@(negedge dclk_in) disable iff (rst)
    (!$past(rst) && $past(lock_gate_en && (pd_mode == LOCKWAIT_CODE)))
      |-> (dclk_pin == !$past(pll_lock))); // R1
endmodule

// File: rtl/rpl_amp_pin.sv
module rpl_amp_pin (
  input  logic clk,
  input  logic rst,
  input  logic func_en,
  input  logic pol,
  input  logic status,
  output logic pin_o
);
  logic pin_next;

  always_comb begin
    if (func_en) pin_next = status ^ ~pol;
    else         pin_next = pol;
  end

  always_ff @(posedge clk) begin
    if (rst) pin_o <= 1'b0;
    else     pin_o <= pin_next;
  end

  AST_DIRECT_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(func_en)) |-> (pin_o == $past(pol))); // R8
  AST_FOLLOW_STATUS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(func_en))
      |-> (pin_o == ($past(pol) ? $past(status) : !$past(status)))); // R7
endmodule

// File: rtl/rpl_lock_pin.sv
module rpl_lock_pin #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] lock_sel,
  input  logic             pll_lock,
  output logic             pin_o
);
  localparam logic [SEL_W-1:0] SEL_LOW  = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_HIGH = SEL_W'(1);

  logic pin_next;

  always_comb begin
    case (lock_sel)
      SEL_LOW:  pin_next = 1'b0;
      SEL_HIGH: pin_next = 1'b1;
      default:  pin_next = pll_lock;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pin_o <= 1'b0;
    else     pin_o <= pin_next;
  end

  AST_SEL_LOW: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(lock_sel) == SEL_LOW)) |-> !pin_o); // R10
  AST_SEL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(lock_sel) == SEL_HIGH)) |-> pin_o); // R10
  AST_SEL_STATUS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(lock_sel) != SEL_LOW) && ($past(lock_sel) != SEL_HIGH))
      |-> (pin_o == $past(pll_lock))); // R10
endmodule

// File: rtl/radio_pin_ctrl.sv
module radio_pin_ctrl
  import radio_pin_pkg::*;
#(
  parameter int PDW   = PD_W,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dclk_in,
  input  logic             pll_lock,
  input  logic             carrier_sense,
  input  logic             pa_on,
  input  logic             lna_on,
  input  logic             rx_mode,
  input  logic [PDW-1:0]   pd_mode,
  input  logic             lock_gate_en,
  input  logic             cs_gate_en,
  input  logic             pa_func,
  input  logic             pa_pol,
  input  logic             lna_func,
  input  logic             lna_pol,
  input  logic [SEL_W-1:0] lock_sel,
  output logic             dclk_pin,
  output logic             pa_pin,
  output logic             lna_pin,
  output logic             lock_pin
);
  rpl_dclk_gate #(.PDW(PDW)) u_gate (
    .rst           (rst),
    .dclk_in       (dclk_in),
    .pll_lock      (pll_lock),
    .carrier_sense (carrier_sense),
    .rx_mode       (rx_mode),
    .pd_mode       (pd_mode),
    .lock_gate_en  (lock_gate_en),
    .cs_gate_en    (cs_gate_en),
    .dclk_pin      (dclk_pin)
  );

  rpl_amp_pin u_pa (
    .clk     (clk),
    .rst     (rst),
    .func_en (pa_func),
    .pol     (pa_pol),
    .status  (pa_on),
    .pin_o   (pa_pin)
  );

  rpl_amp_pin u_lna (
    .clk     (clk),
    .rst     (rst),
    .func_en (lna_func),
    .pol     (lna_pol),
    .status  (lna_on),
    .pin_o   (lna_pin)
  );

  rpl_lock_pin #(.SEL_W(SEL_W)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .lock_sel (lock_sel),
    .pll_lock (pll_lock),
    .pin_o    (lock_pin)
  );
endmodule

// File: tb/sim_radio_pin_ctrl.sv
module sim_radio_pin_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dclk_in = 1'b0;
  logic pll_lock = 1'b0, carrier_sense = 1'b0, pa_on = 1'b0, lna_on = 1'b0;
  logic rx_mode = 1'b0;
  logic [1:0] pd_mode = 2'b00;
  logic lock_gate_en = 1'b0, cs_gate_en = 1'b0;
  logic pa_func = 1'b0, pa_pol = 1'b0, lna_func = 1'b0, lna_pol = 1'b0;
  logic [3:0] lock_sel = 4'b0000;
  logic dclk_pin, pa_pin, lna_pin, lock_pin;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  radio_pin_ctrl u0 (
    .clk(clk), .rst(rst), .dclk_in(dclk_in), .pll_lock(pll_lock),
    .carrier_sense(carrier_sense), .pa_on(pa_on), .lna_on(lna_on),
    .rx_mode(rx_mode), .pd_mode(pd_mode), .lock_gate_en(lock_gate_en),
    .cs_gate_en(cs_gate_en), .pa_func(pa_func), .pa_pol(pa_pol),
    .lna_func(lna_func), .lna_pol(lna_pol), .lock_sel(lock_sel),
    .dclk_pin(dclk_pin), .pa_pin(pa_pin), .lna_pin(lna_pin), .lock_pin(lock_pin)
  );

  always #10 clk = ~clk;

  // {pa_func,pa_pol,pa_on, lna_func,lna_pol,lna_on, lock_sel, pll_lock, exp_pa,exp_lna,exp_lock}
  localparam int NV = 8;
  localparam logic [13:0] VEC [NV] = '{
    14'b111_111_0000_1_110,
    14'b110_101_0001_0_001,
    14'b100_100_0010_1_111,
    14'b101_010_0111_0_010,
    14'b010_001_1111_1_101,
    14'b001_110_0000_0_000,
    14'b011_011_0001_1_111,
    14'b111_001_1000_0_100
  };

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // one data clock pulse; the falling edge latches the gating mode
  task automatic dtick();
    dclk_in = 1'b1; #20;
    dclk_in = 1'b0; #20;
  endtask

  // probe the pin during the high and low phases of one data clock period
  task automatic probe(input logic exp_hi, input logic exp_lo, input string tag);
    dclk_in = 1'b1; #5;
    chk(dclk_pin, exp_hi, tag);
    #15 dclk_in = 1'b0; #5;
    chk(dclk_pin, exp_lo, tag);
    #15;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11: reset with inputs that would otherwise force outputs
    lock_gate_en = 1'b1; pd_mode = 2'b01; pll_lock = 1'b0;
    pa_pol = 1'b1; lna_pol = 1'b1; lock_sel = 4'b0001;
    repeat (3) dtick();
    @(negedge clk); @(negedge clk);
    chk(pa_pin, 1'b0, "R11 pa reset");
    chk(lna_pin, 1'b0, "R11 lna reset");
    chk(lock_pin, 1'b0, "R11 lock reset");
    probe(1'b1, 1'b0, "R11 dclk pass in reset");
    lock_gate_en = 1'b0; pd_mode = 2'b00; pa_pol = 1'b0; lna_pol = 1'b0; lock_sel = 4'b0000;
    @(negedge clk); rst = 1'b0;
    dtick();

    // table walk: R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {pa_func, pa_pol, pa_on, lna_func, lna_pol, lna_on, lock_sel, pll_lock} = VEC[i][13:3];
      @(negedge clk);
      chk(pa_pin, VEC[i][2], VEC[i][13] ? "R7 pa follow" : "R8 pa direct");
      chk(lna_pin, VEC[i][1], "R9 lna");
      chk(lock_pin, VEC[i][0], "R10 lock sel");
    end

    // R8: direct drive ignores pa_on toggling
    @(negedge clk); pa_func = 1'b0; pa_pol = 1'b1; pa_on = 1'b0;
    @(negedge clk); pa_on = 1'b1;
    @(negedge clk); chk(pa_pin, 1'b1, "R8 ignore pa_on");

    // R2: lock gating with pd_mode 00 and 10 passes the clock
    lock_gate_en = 1'b1; pd_mode = 2'b00; pll_lock = 1'b0; cs_gate_en = 1'b0;
    dtick(); probe(1'b1, 1'b0, "R2 pd 00 pass");
    pd_mode = 2'b10;
    dtick(); probe(1'b1, 1'b0, "R2 pd 10 pass");

    // R1: lock wait
    pd_mode = 2'b01; pll_lock = 1'b0;
    dtick(); probe(1'b1, 1'b1, "R1 unlocked high");
    pll_lock = 1'b1;
    dtick(); probe(1'b0, 1'b0, "R1 locked low");

    // R3: carrier-sense gating in receive
    lock_gate_en = 1'b0; pd_mode = 2'b00; cs_gate_en = 1'b1; rx_mode = 1'b1; carrier_sense = 1'b0;
    dtick(); probe(1'b1, 1'b1, "R3 no carrier high");
    carrier_sense = 1'b1;
    dtick(); probe(1'b1, 1'b0, "R3 carrier runs");

    // R4: ignored in transmit
    rx_mode = 1'b0; carrier_sense = 1'b0;
    dtick(); probe(1'b1, 1'b0, "R4 tx pass");

    // R5: lock wait takes priority over carrier sense
    rx_mode = 1'b1; carrier_sense = 1'b1; lock_gate_en = 1'b1; pd_mode = 2'b01; pll_lock = 1'b0;
    dtick(); probe(1'b1, 1'b1, "R5 lock wait wins high");
    pll_lock = 1'b1;
    dtick(); probe(1'b0, 1'b0, "R5 lock wait wins low");

    // R6: change while data clock high takes effect only at falling edge
    lock_gate_en = 1'b0; cs_gate_en = 1'b0; pd_mode = 2'b00;
    dtick();
    dclk_in = 1'b1; #5;
    chk(dclk_pin, 1'b1, "R6 pass before change");
    lock_gate_en = 1'b1; pd_mode = 2'b01; pll_lock = 1'b1; #5;
    chk(dclk_pin, 1'b1, "R6 held until falling edge");
    #10 dclk_in = 1'b0; #5;
    chk(dclk_pin, 1'b0, "R6 applied after falling edge");
    #15;
    probe(1'b0, 1'b0, "R6 stays low");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule